// File: doc/BRIEF.md
# Fine-Grained Thread Select Unit

This unit is the second stage of a single-issue, in-order core that interleaves several hardware threads. On every cycle it chooses at most one thread whose fetched instruction moves on into decode. There is no branch predictor. A thread that starts a long-latency operation is removed from selection until that operation reports back. Such operations are an unresolved branch, a divide or floating-point operation, or a load that missed and must wait on memory. The remaining threads fill the issue slots in the meantime.

Each thread holds a 2-bit stall reason. A stall-start pulse with a non-zero reason writes that reason. A completion pulse clears it only when it carries the same reason. A per-thread enable can park a thread regardless of its stall state. Among eligible threads, a rotating pointer gives the grant to the first eligible thread after the one granted last. If nothing is eligible, a bubble is sent to decode.

Top module: `thread_sel_unit`

## Requirements
- R1: After reset every thread is ready and the rotation starts at thread 0. With all threads enabled and valid, the first selection is thread 0.
- R2: At most one thread is selected per cycle. `sel_valid_o` is high exactly when some thread is enabled, has a valid fetched instruction and is not stalled.
- R3: After thread k is granted, the next grant goes to the first eligible thread found going upward from k+1 with wrap. A thread that stays eligible is therefore passed over for no more than NUM_THREADS-1 cycles in a row.
- R4: A stall-start pulse on a thread with reason 1 (branch), 2 (long arithmetic, divide or floating point) or 3 (memory) removes that thread from selection from the next cycle onward. It stays removed for any length of wait.
- R5: A completion pulse clears a stall only if its reason code equals the stored one. The thread is selectable from the following cycle. A completion with any other code leaves the thread stalled.
- R6: When a stall-start and a completion reach the same thread in one cycle, the stall-start wins. The thread stays stalled with the new reason, and only a completion with that new reason frees it.
- R7: A thread whose enable is low is never selected, whatever its stall state.
- R8: When no thread is eligible, `sel_valid_o` is low and `sel_tid_o` is 0. The rotation pointer does not move on a bubble.
- R9: A stall-start pulse with reason 0 (none) has no effect.
- R10: Selection in a cycle depends on that cycle's enables and valid flags and on stall state registered before that cycle. A stall-start therefore does not block the grant made in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thread_en_i | input | NUM_THREADS | Per-thread enable; low parks the thread |
| fetch_valid_i | input | NUM_THREADS | Per-thread fetched-instruction-valid flag |
| stall_req_i | input | NUM_THREADS | Per-thread stall-start pulse |
| stall_rsn_i | input | 2*NUM_THREADS | Stall reason per thread, thread t at bits [2t+1:2t] |
| done_i | input | NUM_THREADS | Per-thread completion pulse |
| done_rsn_i | input | 2*NUM_THREADS | Completion reason per thread, same layout |
| sel_tid_o | output | TID_W | Selected thread index |
| sel_valid_o | output | 1 | A thread is selected this cycle |

## Verification
The bench builds the unit with its default of four threads and the fixed 2-bit reason field. With four threads, a full rotation and every pointer wrap are reached within a few cycles, as is every reason code. Directed sequences cover skipping of stalled and parked threads and a 40-cycle floating-point wait. They also cover a mismatched completion, a same-cycle stall and completion, and a cycle in which every thread is stalled at once.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;
  typedef enum logic [1:0] {
    RSN_NONE   = 2'd0,
    RSN_BRANCH = 2'd1,
    RSN_ARITH  = 2'd2,
    RSN_MEM    = 2'd3
  } stall_rsn_e;
endpackage

// File: rtl/tsel_thread_state.sv
`timescale 1ns/1ps
module tsel_thread_state
  import tsel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stall_req_i,
  input  stall_rsn_e stall_rsn_i,
  input  logic       done_i,
  input  stall_rsn_e done_rsn_i,
  output logic       ready_o
);
  stall_rsn_e rsn_q, rsn_d;
  logic new_stall, match_done;

  assign new_stall  = stall_req_i && (stall_rsn_i != RSN_NONE);
  assign match_done = done_i && (done_rsn_i == rsn_q);

  always_comb begin
    rsn_d = rsn_q;
    if (new_stall)       rsn_d = stall_rsn_i;  // new event wins over completion
    else if (match_done) rsn_d = RSN_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsn_q <= RSN_NONE;
    else         rsn_q <= rsn_d;
  end

  assign ready_o = (rsn_q == RSN_NONE);

  p_stall_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_stall |=> (!ready_o && rsn_q == $past(stall_rsn_i)));
  p_match_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && match_done && !new_stall) |=> ready_o);
  p_mismatch_holds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !match_done && !new_stall) |=> $stable(rsn_q));
  p_collide_stays_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_stall && done_i) |=> !ready_o);
  p_none_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !new_stall) |=> ready_o);
endmodule

// File: rtl/tsel_rr_arbiter.sv
`timescale 1ns/1ps
module tsel_rr_arbiter #(
  parameter int N    = 4,
  localparam int TW  = (N > 1) ? $clog2(N) : 1,
  localparam int CW  = $clog2(N) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [TW-1:0] gnt_idx_o,
  output logic          gnt_valid_o
);
  logic [TW-1:0] ptr_q, ptr_d;
  logic [N-1:0]  grant;
  logic [TW:0]   cand;
  logic          found;

  always_comb begin
    grant     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    cand      = '0;
    for (int off = 0; off < N; off++) begin
      cand = {1'b0, ptr_q} + (TW+1)'(off);
      if (cand >= (TW+1)'(N)) cand = cand - (TW+1)'(N);
      if (!found && req_i[cand[TW-1:0]]) begin
        found                 = 1'b1;
        grant[cand[TW-1:0]]   = 1'b1;
        gnt_idx_o             = cand[TW-1:0];
      end
    end
  end

  assign gnt_valid_o = found;

  always_comb begin
    ptr_d = ptr_q;
    if (found) ptr_d = (gnt_idx_o == TW'(N-1)) ? '0 : gnt_idx_o + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  // consecutive cycles each requester has been passed over
  logic [N-1:0][CW-1:0] wait_q;
  for (genvar i = 0; i < N; i++) begin : g_wait
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   wait_q[i] <= '0;
      else if (req_i[i] && !grant[i]) wait_q[i] <= wait_q[i] + 1'b1;
      else                           wait_q[i] <= '0;
    end
    p_wait_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[i] && !grant[i]) |-> (wait_q[i] < CW'(N-1)));
  end

  p_one_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  p_grant_requested_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant & ~req_i) == '0);
  p_ptr_still_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found |=> $stable(ptr_q));
endmodule

// File: rtl/thread_sel_unit.sv
`timescale 1ns/1ps
module thread_sel_unit
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_THREADS-1:0]   thread_en_i,
  input  logic [NUM_THREADS-1:0]   fetch_valid_i,
  input  logic [NUM_THREADS-1:0]   stall_req_i,
  input  logic [2*NUM_THREADS-1:0] stall_rsn_i,
  input  logic [NUM_THREADS-1:0]   done_i,
  input  logic [2*NUM_THREADS-1:0] done_rsn_i,
  output logic [TID_W-1:0]         sel_tid_o,
  output logic                     sel_valid_o
);
  logic [NUM_THREADS-1:0] ready, eligible;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    tsel_thread_state u_state (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .stall_req_i (stall_req_i[t]),
      .stall_rsn_i (stall_rsn_e'(stall_rsn_i[2*t+:2])),
      .done_i      (done_i[t]),
      .done_rsn_i  (stall_rsn_e'(done_rsn_i[2*t+:2])),
      .ready_o     (ready[t])
    );
  end

  assign eligible = thread_en_i & fetch_valid_i & ready;

  tsel_rr_arbiter #(.N(NUM_THREADS)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (eligible),
    .gnt_idx_o   (sel_tid_o),
    .gnt_valid_o (sel_valid_o)
  );

  p_parked_never_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (thread_en_i[sel_tid_o] && fetch_valid_i[sel_tid_o]));
  p_bubble_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> (sel_tid_o == '0));
  p_valid_iff_eligible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o == (|eligible));
endmodule

// File: tb/thread_sel_unit_tb_top.sv
`timescale 1ns/1ps
module thread_sel_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] thread_en_i = '0, fetch_valid_i = '0, stall_req_i = '0, done_i = '0;
  logic [2*NT-1:0] stall_rsn_i = '0, done_rsn_i = '0;
  logic [1:0]    sel_tid_o;
  logic          sel_valid_o;

  logic [NT-1:0]   st_req = '0, st_done = '0;
  logic [2*NT-1:0] st_rsn = '0, st_drsn = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_sel_unit #(.NUM_THREADS(NT)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .thread_en_i(thread_en_i),
    .fetch_valid_i(fetch_valid_i), .stall_req_i(stall_req_i),
    .stall_rsn_i(stall_rsn_i), .done_i(done_i), .done_rsn_i(done_rsn_i),
    .sel_tid_o(sel_tid_o), .sel_valid_o(sel_valid_o)
  );

  task automatic check(input bit xv, input int xt, input string tag);
    n_chk++;
    if (sel_valid_o !== xv || sel_tid_o !== 2'(xt)) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
               tag, sel_valid_o, sel_tid_o, xv, xt);
    end
  endtask

  task automatic stage_stall(input int t, input logic [1:0] k);
    st_req[t] = 1'b1; st_rsn[2*t+:2] = k;
  endtask

  task automatic stage_done(input int t, input logic [1:0] k);
    st_done[t] = 1'b1; st_drsn[2*t+:2] = k;
  endtask

  // one cycle: drive at negedge, check combinational select just after
  task automatic cyc(input logic [NT-1:0] f, input logic [NT-1:0] e,
                     input bit xv, input int xt, input string tag);
    @(negedge clk);
    fetch_valid_i = f; thread_en_i = e;
    stall_req_i = st_req; stall_rsn_i = st_rsn;
    done_i = st_done; done_rsn_i = st_drsn;
    st_req = '0; st_rsn = '0; st_done = '0; st_drsn = '0;
    #1 check(xv, xt, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; fetch_valid_i = '0; thread_en_i = '0;
    stall_req_i = '0; done_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_rotation();
    do_reset();
    #1 check(0, 0, "R1 idle after reset");
    cyc('1, '1, 1, 0, "R1 first grant");
    cyc('1, '1, 1, 1, "R3 rotate");
    cyc('1, '1, 1, 2, "R3 rotate");
    cyc('1, '1, 1, 3, "R3 rotate");
    cyc('1, '1, 1, 0, "R3 wrap");
    cyc(4'b1010, '1, 1, 1, "R3 sparse");
    cyc(4'b1010, '1, 1, 3, "R3 sparse");
    cyc(4'b1010, '1, 1, 1, "R3 sparse wrap");
    cyc(4'b1101, '1, 1, 2, "R10 mask change");
    cyc(4'b1101, '1, 1, 3, "R3 next");
    cyc(4'b1101, '1, 1, 0, "R3 wrap");
  endtask

  task automatic t_bubble();
    do_reset();
    cyc('0, '1, 0, 0, "R8 no fetch valid");
    cyc('1, '0, 0, 0, "R8 all parked");
    cyc(4'b0100, '1, 1, 2, "R2 single eligible");
  endtask

  task automatic t_park();
    do_reset();
    cyc('1, 4'b1011, 1, 0, "R7 park");
    cyc('1, 4'b1011, 1, 1, "R7 park");
    cyc('1, 4'b1011, 1, 3, "R7 skip parked");
    cyc(4'b0100, 4'b1011, 0, 0, "R7 parked only");
    cyc(4'b0100, '1, 1, 2, "R8 pointer held over bubble");
  endtask

  task automatic t_branch();
    do_reset();
    stage_stall(1, 2'd1);
    cyc('1, '1, 1, 0, "R10 grant in stall cycle");
    cyc('1, '1, 1, 2, "R4 branch skipped");
    cyc('1, '1, 1, 3, "R4 branch skipped");
    cyc('1, '1, 1, 0, "R4 branch skipped");
    cyc(4'b0010, '1, 0, 0, "R4 branch stalled");
    stage_done(1, 2'd3);
    cyc(4'b0010, '1, 0, 0, "R5 mismatch cycle");
    cyc(4'b0010, '1, 0, 0, "R5 mismatch ignored");
    stage_done(1, 2'd1);
    cyc(4'b0010, '1, 0, 0, "R5 match cycle");
    cyc(4'b0010, '1, 1, 1, "R5 branch resolved");
  endtask

  task automatic t_fp();
    do_reset();
    stage_stall(3, 2'd2);
    cyc('1, '1, 1, 0, "R4 fp issue");
    for (int i = 0; i < 40; i++) cyc(4'b1000, '1, 0, 0, "R4 fp wait");
    stage_done(3, 2'd2);
    cyc(4'b1000, '1, 0, 0, "R5 fp return cycle");
    cyc(4'b1000, '1, 1, 3, "R5 fp resumed");
  endtask

  task automatic t_collide();
    do_reset();
    stage_stall(0, 2'd3);
    cyc(4'b0001, '1, 1, 0, "R4 mem issue");
    cyc(4'b0001, '1, 0, 0, "R4 mem stalled");
    stage_done(0, 2'd3); stage_stall(0, 2'd1);
    cyc(4'b0001, '1, 0, 0, "R6 collide cycle");
    cyc(4'b0001, '1, 0, 0, "R6 new event wins");
    stage_done(0, 2'd3);
    cyc(4'b0001, '1, 0, 0, "R6 old reason");
    cyc(4'b0001, '1, 0, 0, "R6 old reason ignored");
    stage_done(0, 2'd1);
    cyc(4'b0001, '1, 0, 0, "R6 new reason cycle");
    cyc(4'b0001, '1, 1, 0, "R6 freed");
  endtask

  task automatic t_none_and_all();
    do_reset();
    stage_stall(2, 2'd0);
    cyc(4'b0100, '1, 1, 2, "R9 none code");
    cyc(4'b0100, '1, 1, 2, "R9 still ready");
    stage_stall(0, 2'd1); stage_stall(1, 2'd2);
    stage_stall(2, 2'd3); stage_stall(3, 2'd1);
    cyc('1, '1, 1, 3, "R10 grant in stall cycle");
    cyc('1, '1, 0, 0, "R8 all stalled");
  endtask

  initial begin
    t_rotation();
    t_bubble();
    t_park();
    t_branch();
    t_fp();
    t_collide();
    t_none_and_all();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule